// File: doc/BRIEF.md
# Overlay Cell Code Resolver

This block turns a text-overlay scan position into the glyph code and attribute flag for that cell. The overlay has 24 columns and 12 rows. Each display row has a start pointer into a character line table; the table holds 64 lines of 24 one-byte entries. A table entry either names a fixed glyph (0 to 127) or marks the cell as variable. A variable cell takes its glyph and attribute from a shared 176-entry variable RAM.

No cell holds a RAM address. The RAM entries are handed out in the order in which the scan reaches variable cells. The first variable cell after a frame start takes entry 0, and each later variable cell takes the next entry. This lets the fixed text sit in the table while the changing text is packed densely in the RAM.

The scan walks columns 0 to 23 of a row and then moves to the next row. Both memories are read asynchronously through address outputs and data inputs. The result is registered and comes out one clock after the scan position.

Top module: `osd_code_resolver`

## Requirements
- R1: For an in-range cell, `lt_addr` equals the row's 11-bit start pointer plus the column number. The pointer for row r sits in `row_base_flat[11*r+10 : 11*r]`.
- R2: If bit 7 of the table entry is 0, the output code is entry bits 6:0 and `cell_attr` is 0.
- R3: If bit 7 of the table entry is 1, the cell is variable. The output code is RAM entry bits 6:0 and `cell_attr` is RAM entry bit 7.
- R4: Each variable cell reads the RAM at the current allocation index. The index then advances by one. Fixed cells leave the index unchanged.
- R5: A `frame_start` pulse clears the index. A cell presented in the same cycle as the pulse already uses index 0.
- R6: The index saturates at 175. Every variable cell beyond the 176th in a frame reads entry 175.
- R7: `cell_valid` is 1 exactly one clock after an in-range scan, and the code and attribute appear in that same cycle.
- R8: Some scans are ignored: those with `scan_valid` low, row 12 or above, or column 24 or above. For them, `cell_valid` is 0 one clock later, code and attribute hold their values, and the index does not advance.
- R9: After reset, `cell_valid`, `cell_code` and `cell_attr` are 0, and the index starts at 0 even without a `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_base_flat | input | 132 | Twelve 11-bit line-table start pointers, row 0 in the low bits |
| frame_start | input | 1 | Frame start pulse; clears the allocation index |
| scan_valid | input | 1 | Scan position is presented this cycle |
| scan_row | input | 4 | Display row of the scanned cell |
| scan_col | input | 5 | Column of the scanned cell |
| lt_addr | output | 11 | Line-table read address |
| lt_data | input | 8 | Line-table entry at `lt_addr` (asynchronous read) |
| ram_addr | output | 8 | Variable RAM read address (allocation index) |
| ram_data | input | 8 | Variable RAM entry at `ram_addr` (asynchronous read) |
| cell_valid | output | 1 | Registered result valid |
| cell_code | output | 7 | Resolved glyph code |
| cell_attr | output | 1 | Resolved attribute flag |

## Verification
The read addresses `lt_addr` and `ram_addr` are combinational, so they are due in the same cycle as the scan position. The bench drives each position on a falling edge and checks both addresses one time step later, before the next rising edge. `cell_valid`, `cell_code` and `cell_attr` pass through one register, so the bench checks them on the following falling edge. It drives the next position at that same point, which lets every cycle of a full frame sweep be checked without gaps. The expected allocation index is kept as a separate counter in the bench. It is cleared on a frame start and saturates at 175.

// File: rtl/osd_res_pkg.sv
package osd_res_pkg;
  localparam int GLYPH_W = 7;

  typedef struct packed {
    logic               attr;
    logic [GLYPH_W-1:0] code;
  } cell_t;

  // bit 7 of a line-table entry selects the variable RAM
  localparam int REDIRECT_BIT = 7;
endpackage

// File: rtl/osd_row_addr.sv
module osd_row_addr #(
  parameter int COLS  = 24,
  parameter int ROWS  = 12,
  parameter int LT_AW = 11,
  parameter int ROW_W = 4,
  parameter int COL_W = 5
) (
  input  logic [ROWS*LT_AW-1:0] row_base_flat,
  input  logic [ROW_W-1:0]      scan_row,
  input  logic [COL_W-1:0]      scan_col,
  output logic                  in_range,
  output logic [LT_AW-1:0]      lt_addr
);
  logic [LT_AW-1:0] bases [ROWS];
  logic [LT_AW-1:0] base_sel;

  for (genvar r = 0; r < ROWS; r++) begin : g_unpack
    assign bases[r] = row_base_flat[r*LT_AW +: LT_AW];
  end

  always_comb begin
    in_range = (int'(scan_row) < ROWS) && (int'(scan_col) < COLS);
    base_sel = '0;
    if (in_range) base_sel = bases[scan_row];
    lt_addr  = base_sel + LT_AW'(scan_col);
  end
endmodule

// File: rtl/osd_var_alloc.sv
module osd_var_alloc #(
  parameter int RAM_DEPTH = 176,
  parameter int RAM_AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              take,
  output logic [RAM_AW-1:0] ram_addr
);
  localparam logic [RAM_AW-1:0] LAST = RAM_AW'(RAM_DEPTH - 1);

  logic [RAM_AW-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    ram_addr = frame_start ? '0 : cnt_q;
    cnt_en   = frame_start | take;
    cnt_d    = ram_addr;
    if (take && ram_addr != LAST) cnt_d = ram_addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/osd_cell_reg.sv
module osd_cell_reg
  import osd_res_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  cell_t cell_d,
  output logic  valid_q,
  output cell_t cell_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cell_q <= '0;
    else if (load) cell_q <= cell_d;
  end
endmodule

// File: rtl/osd_code_resolver.sv
module osd_code_resolver
  import osd_res_pkg::*;
#(
  parameter int COLS      = 24,
  parameter int ROWS      = 12,
  parameter int LT_AW     = 11,
  parameter int RAM_DEPTH = 176,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int COL_W    = $clog2(COLS),
  localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ROWS*LT_AW-1:0] row_base_flat,
  input  logic                  frame_start,
  input  logic                  scan_valid,
  input  logic [ROW_W-1:0]      scan_row,
  input  logic [COL_W-1:0]      scan_col,
  output logic [LT_AW-1:0]      lt_addr,
  input  logic [7:0]            lt_data,
  output logic [RAM_AW-1:0]     ram_addr,
  input  logic [7:0]            ram_data,
  output logic                  cell_valid,
  output logic [GLYPH_W-1:0]    cell_code,
  output logic                  cell_attr
);
  logic  in_range, hit, redirect;
  cell_t cell_d, cell_q;

  osd_row_addr #(
    .COLS(COLS), .ROWS(ROWS), .LT_AW(LT_AW), .ROW_W(ROW_W), .COL_W(COL_W)
  ) row_addr_i (
    .row_base_flat(row_base_flat),
    .scan_row     (scan_row),
    .scan_col     (scan_col),
    .in_range     (in_range),
    .lt_addr      (lt_addr)
  );

  always_comb begin
    hit      = scan_valid & in_range;
    redirect = lt_data[REDIRECT_BIT];
    if (redirect) cell_d = cell_t'(ram_data);
    else          cell_d = '{attr: 1'b0, code: lt_data[GLYPH_W-1:0]};
  end

  osd_var_alloc #(.RAM_DEPTH(RAM_DEPTH), .RAM_AW(RAM_AW)) alloc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .take       (hit & redirect),
    .ram_addr   (ram_addr)
  );

  osd_cell_reg out_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (hit),
    .cell_d (cell_d),
    .valid_q(cell_valid),
    .cell_q (cell_q)
  );

  assign cell_code = cell_q.code;
  assign cell_attr = cell_q.attr;
endmodule

// File: rtl/osd_code_resolver_chk.sv
module osd_code_resolver_chk #(
  parameter int COLS      = 24,
  parameter int ROWS      = 12,
  parameter int LT_AW     = 11,
  parameter int RAM_DEPTH = 176,
  parameter int ROW_W     = 4,
  parameter int COL_W     = 5,
  parameter int RAM_AW    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ROWS*LT_AW-1:0] row_base_flat,
  input logic                  frame_start,
  input logic                  scan_valid,
  input logic [ROW_W-1:0]      scan_row,
  input logic [COL_W-1:0]      scan_col,
  input logic [LT_AW-1:0]      lt_addr,
  input logic [7:0]            lt_data,
  input logic [RAM_AW-1:0]     ram_addr,
  input logic [7:0]            ram_data,
  input logic                  cell_valid,
  input logic [6:0]            cell_code,
  input logic                  cell_attr
);
  localparam logic [RAM_AW-1:0] LAST = RAM_AW'(RAM_DEPTH - 1);

  logic hit, var_hit;
  assign hit     = scan_valid && (int'(scan_row) < ROWS) && (int'(scan_col) < COLS);
  assign var_hit = hit && lt_data[7];

  a_r1_line_addr: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> lt_addr == LT_AW'(row_base_flat[scan_row*LT_AW +: LT_AW] + LT_AW'(scan_col)));

  a_r2_fixed_cell: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !lt_data[7]) |=> (!cell_attr && cell_code == $past(lt_data[6:0])));

  a_r3_variable_cell: assert property (@(posedge clk) disable iff (!rst_n)
    var_hit |=> ({cell_attr, cell_code} == $past(ram_data)));

  a_r4_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    var_hit |=> (frame_start || !var_hit ||
                 ram_addr == (($past(ram_addr) == LAST) ? LAST : $past(ram_addr) + 1'b1)));

  a_r5_frame_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && var_hit) |-> ram_addr == '0);

  a_r6_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ram_addr <= LAST);

  a_r7_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cell_valid);

  a_r8_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (!cell_valid && $stable(cell_code) && $stable(cell_attr)));

  a_r8_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!var_hit && !frame_start) |=> (frame_start || $stable(ram_addr)));
endmodule

bind osd_code_resolver osd_code_resolver_chk #(
  .COLS(COLS), .ROWS(ROWS), .LT_AW(LT_AW), .RAM_DEPTH(RAM_DEPTH),
  .ROW_W(ROW_W), .COL_W(COL_W), .RAM_AW(RAM_AW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .row_base_flat(row_base_flat),
  .frame_start(frame_start), .scan_valid(scan_valid),
  .scan_row(scan_row), .scan_col(scan_col),
  .lt_addr(lt_addr), .lt_data(lt_data),
  .ram_addr(ram_addr), .ram_data(ram_data),
  .cell_valid(cell_valid), .cell_code(cell_code), .cell_attr(cell_attr)
);

// File: tb/osd_code_resolver_tb_top.sv
module osd_code_resolver_tb_top;
  localparam int ROWS = 12, COLS = 24, LT_AW = 11, DEPTH = 176, LT_SIZE = 1536;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ROWS*LT_AW-1:0] row_base_flat;
  logic              frame_start, scan_valid;
  logic [3:0]        scan_row;
  logic [4:0]        scan_col;
  logic [10:0]       lt_addr;
  logic [7:0]        lt_data;
  logic [7:0]        ram_addr;
  logic [7:0]        ram_data;
  logic              cell_valid;
  logic [6:0]        cell_code;
  logic              cell_attr;

  logic [7:0] lt_mem  [LT_SIZE];
  logic [7:0] ram_mem [DEPTH];
  int         base    [ROWS];

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int m_idx = 0;
  int e_code = 0, e_attr = 0;

  always #2 clk = ~clk;

  assign lt_data  = (int'(lt_addr) < LT_SIZE) ? lt_mem[lt_addr] : 8'h00;
  assign ram_data = (int'(ram_addr) < DEPTH) ? ram_mem[ram_addr] : 8'h00;

  osd_code_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .row_base_flat(row_base_flat),
    .frame_start(frame_start), .scan_valid(scan_valid),
    .scan_row(scan_row), .scan_col(scan_col),
    .lt_addr(lt_addr), .lt_data(lt_data),
    .ram_addr(ram_addr), .ram_data(ram_data),
    .cell_valid(cell_valid), .cell_code(cell_code), .cell_attr(cell_attr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_bases();
    for (int r = 0; r < ROWS; r++) row_base_flat[r*LT_AW +: LT_AW] = LT_AW'(base[r]);
  endtask

  // called on a falling edge; returns on the next falling edge
  task automatic drive(input int r, input int c, input bit fs, input bit sv);
    bit hit;
    int a, e, exp_valid;
    frame_start = fs; scan_valid = sv;
    scan_row = 4'(r); scan_col = 5'(c);
    hit = sv && r < ROWS && c < COLS;
    if (fs) m_idx = 0;
    exp_valid = hit ? 1 : 0;
    #1;
    if (hit) begin
      a = base[r] + c;
      chk("R1 lt_addr", int'(lt_addr), a);
      e = int'(lt_mem[a]);
      if (e >= 128) begin
        if (fs)                 chk("R5 ram_addr", int'(ram_addr), m_idx);
        else if (m_idx == DEPTH-1) chk("R6 ram_addr", int'(ram_addr), m_idx);
        else                    chk("R4 ram_addr", int'(ram_addr), m_idx);
        e_code = int'(ram_mem[m_idx]) % 128;
        e_attr = int'(ram_mem[m_idx]) / 128;
        if (m_idx < DEPTH-1) m_idx++;
      end else begin
        e_code = e;
        e_attr = 0;
      end
    end
    @(negedge clk);
    chk("R7 cell_valid", int'(cell_valid), exp_valid);
    if (hit) begin
      chk(lt_mem[base[r]+c][7] ? "R3 code" : "R2 code", int'(cell_code), e_code);
      chk(lt_mem[base[r]+c][7] ? "R3 attr" : "R2 attr", int'(cell_attr), e_attr);
    end else begin
      chk("R8 code hold", int'(cell_code), e_code);
      chk("R8 attr hold", int'(cell_attr), e_attr);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int a = 0; a < LT_SIZE; a++)
      lt_mem[a] = (a % 5 == 3) ? 8'h80 : 8'((a * 13) % 128);
    for (int i = 0; i < DEPTH; i++) ram_mem[i] = 8'((i * 37 + 11) % 256);
    for (int r = 0; r < ROWS; r++) base[r] = 24 * ((r * 5 + 2) % 64);
    load_bases();
    rst_n = 1'b0; frame_start = 1'b0; scan_valid = 1'b0;
    scan_row = '0; scan_col = '0;
    repeat (3) @(negedge clk);
    chk("R9 valid at reset", int'(cell_valid), 0);
    chk("R9 code at reset", int'(cell_code), 0);
    chk("R9 attr at reset", int'(cell_attr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 valid after reset", int'(cell_valid), 0);

    // R9: first frame after reset, no frame_start
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) drive(r, c, 1'b0, 1'b1);

    // R5: frame_start coincides with first cell
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) drive(r, c, (r == 0 && c == 0), 1'b1);

    // R8: frame_start on an idle cycle, then ignored scans interleaved
    drive(0, 0, 1'b1, 1'b0);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        drive(r, c, 1'b0, 1'b1);
        case (c % 3)
          0: drive(12 + (c % 4), c, 1'b0, 1'b1);
          1: drive(r, 24 + (c % 8), 1'b0, 1'b1);
          default: drive(r, c, 1'b0, 1'b0);
        endcase
      end

    // R6: every cell variable, index saturates at 175
    for (int a = 0; a < ROWS * COLS; a++) lt_mem[a] = 8'h80;
    for (int r = 0; r < ROWS; r++) base[r] = 24 * r;
    load_bases();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) drive(r, c, (r == 0 && c == 0), 1'b1);
    // R5: a new frame restarts at entry 0 after saturation
    for (int c = 0; c < COLS; c++) drive(0, c, (c == 0), 1'b1);

    summary();
  end
endmodule